// File: doc/BRIEF.md
# Dual-Queue Interprocessor Mailbox

This block lets two processors pass 32-bit words to each other through two small message queues. Each processor, called a user, has its own register port. Writing a mailbox's message register appends a word to that queue. Reading the same register removes the oldest word and returns it. Per-mailbox registers report the fill level and a full flag.

For every mailbox, each user holds a sticky new-message event and a sticky not-full event. Each user also has an enable mask and an interrupt line. The events follow the queue level. A write-one acknowledge clears an event only when its condition has gone away; otherwise the event stays set and the interrupt stays asserted. A receiver reads the count, reads the message register that many times, and then acknowledges.

Each user port carries requests as valid/ready. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. A port whose request is not accepted must hold it unchanged until it is. `req_ready` drops only when the other, lower-numbered user targets the same mailbox message register with the same direction in the same cycle. Every other request is accepted at once. A read response comes back one cycle later on `rsp_valid`/`rsp_data` and cannot be stalled.

Top module: `ipc_mailbox`

Register map, word addresses on `req_addr` (m is the mailbox number):
- 0+m: message register.
- 4+m: count, in bits [2:0].
- 8+m: full flag, in bit 0.
- 12: the requesting user's own event status.
- 13: the requesting user's own enable mask.

## Requirements
- R1: An accepted write to message register m (address m) of a mailbox that is not full appends the word. The count at address 4+m reads one higher from the next cycle on.
- R2: An accepted read of message register m returns the oldest queued word and removes it, so words come out in write order. `rsp_valid` is high and `rsp_data` holds the word exactly one cycle after acceptance.
- R3: A mailbox holds at most 4 words. A write to a mailbox holding 4 words, with no pop in the same cycle, is dropped and the count stays 4. Address 8+m reads 1 in bit 0 exactly when the count is 4.
- R4: A read of an empty mailbox returns 0, and its count stays 0.
- R5: In one cycle, one user may write and the other may read the same mailbox. If the mailbox is not empty, the pop takes the oldest word and the count does not change. This holds even when the mailbox is full, in which case the written word is kept.
- R6: If both users target the same message register with the same direction in one cycle, user 0 is served. User 1 sees `req_ready` low and is served once it holds its request into a cycle without that conflict.
- R7: In each user's status register, bit 2m is mailbox m new-message and bit 2m+1 is mailbox m not-full. On the edge where the count is updated, new-message sets if the count is not zero, and not-full sets if the count is below 4. Both bits stay set until acknowledged.
- R8: Writing address 12 with a 1 in a bit clears that bit only if its condition is false after that edge; if the condition still holds, the bit stays set. Writing 0 in a bit leaves it unchanged.
- R9: Address 13 holds the user's enable mask, with the same bit layout. `irq[u]` is high in the same cycle that any bit of user u's status register and enable mask are both 1.
- R10: During and right after reset, all queues are empty, all enables and status bits are 0, and `irq` and `rsp_valid` are low.
- R11: Writes to the count, full or unmapped addresses have no effect. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | NUM_USERS | Request present, one bit per user |
| req_ready | output | NUM_USERS | Request accepted this cycle if valid |
| req_write | input | NUM_USERS | 1 = write, 0 = read |
| req_addr | input | NUM_USERS*4 | Word address per user |
| req_wdata | input | NUM_USERS*DATA_W | Write data per user |
| rsp_valid | output | NUM_USERS | Read data valid, one cycle after acceptance |
| rsp_data | output | NUM_USERS*DATA_W | Read data per user |
| irq | output | NUM_USERS | Interrupt line per user |

## Verification
Timing is fixed. `req_ready` depends only on the current requests, so it is settled within the cycle. Read responses arrive one edge after acceptance. Counts and status bits update on the acceptance edge. `irq` follows status and enable in the same cycle.

The bench drives inputs on the falling edge. It checks `req_ready` against its own model just before the rising edge. It compares `rsp_valid`, `rsp_data` and `irq` on the next falling edge, after the model has taken the same edge. The directed read-back checks use that same slot, one edge after the request.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int MBX_AW = 4;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MSG,
    SEL_CNT,
    SEL_FULL,
    SEL_ISTAT,
    SEL_IEN
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e   sel;
    logic [1:0] box;
  } reg_dec_t;

  // Address bits [3:2] pick the register group, [1:0] the mailbox.
  function automatic reg_dec_t mbx_decode(logic [MBX_AW-1:0] a, int nbox);
    reg_dec_t d;
    d.box = a[1:0];
    unique case (a[3:2])
      2'd0: d.sel = SEL_MSG;
      2'd1: d.sel = SEL_CNT;
      2'd2: d.sel = SEL_FULL;
      default: begin
        if (a[1:0] == 2'd0)      d.sel = SEL_ISTAT;
        else if (a[1:0] == 2'd1) d.sel = SEL_IEN;
        else                     d.sel = SEL_NONE;
      end
    endcase
    if ((d.sel == SEL_MSG || d.sel == SEL_CNT || d.sel == SEL_FULL) &&
        int'(d.box) >= nbox)
      d.sel = SEL_NONE;
    return d;
  endfunction

endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           push,
  input  logic                           pop,
  input  logic [DATA_W-1:0]              wdata,
  output logic [DATA_W-1:0]              head,
  output logic [$clog2(DEPTH+1)-1:0]     count,
  output logic [$clog2(DEPTH+1)-1:0]     count_nxt
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH-1);

  logic [DATA_W-1:0] slots [DEPTH];
  logic [PW-1:0]     rd_ptr, wr_ptr;
  logic              pop_do, push_do;

  // A pop frees a slot in the same cycle, so a full queue can still take a write.
  assign pop_do    = pop && (count != '0);
  assign push_do   = push && ((count != FULL_CNT) || pop_do);
  assign count_nxt = count + CW'(push_do) - CW'(pop_do);
  assign head      = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      count <= count_nxt;
      if (pop_do)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      if (push_do) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_do) slots[wr_ptr] <= wdata;
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);
  a_r3_full_drop: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && count == FULL_CNT) |=> (count == FULL_CNT));
  a_r4_empty_pop: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && count == '0) |=> (count == '0));
  a_r5_push_pop_keep: assert property (@(posedge clk) disable iff (rst)
    (push && pop && count != '0) |=> (count == $past(count)));

endmodule

// File: rtl/mbx_grant.sv
module mbx_grant #(
  parameter int NUM_USERS = 2
) (
  input  logic [NUM_USERS-1:0] req,
  output logic [NUM_USERS-1:0] gnt
);
  // Fixed priority: the lowest-numbered requester wins.
  always_comb begin
    logic taken;
    taken = 1'b0;
    gnt   = '0;
    for (int u = 0; u < NUM_USERS; u++) begin
      if (req[u] && !taken) begin
        gnt[u] = 1'b1;
        taken  = 1'b1;
      end
    end
  end

  always_comb begin
    a_r6_single_grant: assert ($onehot0(gnt) && ((gnt & ~req) == '0));
  end

endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl #(
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] ack,
  input  logic          en_we,
  input  logic [SW-1:0] en_wdata,
  input  logic [SW-1:0] cond,
  output logic [SW-1:0] stat,
  output logic [SW-1:0] en,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
      en   <= '0;
    end else begin
      // Level re-arm: a still-true condition wins over the acknowledge.
      stat <= (stat & ~ack) | cond;
      if (en_we) en <= en_wdata;
    end
  end

  assign irq = |(stat & en);

  for (genvar k = 0; k < SW; k++) begin : g_bit
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
      (ack[k] && !cond[k]) |=> !stat[k]);
    a_r8_ack_rearms: assert property (@(posedge clk) disable iff (rst)
      (ack[k] && cond[k]) |=> stat[k]);
    a_r8_zero_keeps: assert property (@(posedge clk) disable iff (rst)
      (stat[k] && !ack[k]) |=> stat[k]);
  end

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbx_pkg::*;
#(
  parameter int NUM_USERS = 2,
  parameter int NUM_BOXES = 2,
  parameter int DEPTH     = 4,
  parameter int DATA_W    = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_USERS-1:0]          req_valid,
  output logic [NUM_USERS-1:0]          req_ready,
  input  logic [NUM_USERS-1:0]          req_write,
  input  logic [NUM_USERS*MBX_AW-1:0]   req_addr,
  input  logic [NUM_USERS*DATA_W-1:0]   req_wdata,
  output logic [NUM_USERS-1:0]          rsp_valid,
  output logic [NUM_USERS*DATA_W-1:0]   rsp_data,
  output logic [NUM_USERS-1:0]          irq
);
  localparam int AW = MBX_AW;
  localparam int SW = 2 * NUM_BOXES;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  reg_dec_t            dec     [NUM_USERS];
  logic [DATA_W-1:0]   wdat    [NUM_USERS];
  logic [NUM_USERS-1:0] wr_req [NUM_BOXES];
  logic [NUM_USERS-1:0] rd_req [NUM_BOXES];
  logic [NUM_USERS-1:0] wr_gnt [NUM_BOXES];
  logic [NUM_USERS-1:0] rd_gnt [NUM_BOXES];
  logic [DATA_W-1:0]   head    [NUM_BOXES];
  logic [CW-1:0]       cnt_q   [NUM_BOXES];
  logic [CW-1:0]       cnt_nxt [NUM_BOXES];
  logic [SW-1:0]       cond;
  logic [SW-1:0]       stat_u  [NUM_USERS];
  logic [SW-1:0]       en_u    [NUM_USERS];

  // ---------------- request decode ----------------
  always_comb begin
    for (int u = 0; u < NUM_USERS; u++) begin
      dec[u]  = mbx_decode(req_addr[u*AW +: AW], NUM_BOXES);
      wdat[u] = req_wdata[u*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    for (int m = 0; m < NUM_BOXES; m++) begin
      for (int u = 0; u < NUM_USERS; u++) begin
        wr_req[m][u] = req_valid[u] && req_write[u] &&
                       (dec[u].sel == SEL_MSG) && (dec[u].box == 2'(m));
        rd_req[m][u] = req_valid[u] && !req_write[u] &&
                       (dec[u].sel == SEL_MSG) && (dec[u].box == 2'(m));
      end
    end
  end

  // A user is held off only when it loses a message-register conflict.
  always_comb begin
    for (int u = 0; u < NUM_USERS; u++) begin
      logic blocked;
      blocked = 1'b0;
      for (int m = 0; m < NUM_BOXES; m++) begin
        blocked = blocked | (wr_req[m][u] & ~wr_gnt[m][u])
                          | (rd_req[m][u] & ~rd_gnt[m][u]);
      end
      req_ready[u] = ~blocked;
    end
  end

  // ---------------- per-mailbox queues ----------------
  for (genvar m = 0; m < NUM_BOXES; m++) begin : g_box
    logic [DATA_W-1:0] push_data;

    mbx_grant #(.NUM_USERS(NUM_USERS)) u_wr_arb (
      .req (wr_req[m]),
      .gnt (wr_gnt[m])
    );

    mbx_grant #(.NUM_USERS(NUM_USERS)) u_rd_arb (
      .req (rd_req[m]),
      .gnt (rd_gnt[m])
    );

    always_comb begin
      push_data = '0;
      for (int u = 0; u < NUM_USERS; u++) begin
        if (wr_gnt[m][u]) push_data = push_data | wdat[u];
      end
    end

    mbx_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
      .clk       (clk),
      .rst       (rst),
      .push      (|wr_gnt[m]),
      .pop       (|rd_gnt[m]),
      .wdata     (push_data),
      .head      (head[m]),
      .count     (cnt_q[m]),
      .count_nxt (cnt_nxt[m])
    );

    // Conditions look at the post-edge level so status and count move together.
    assign cond[2*m]   = (cnt_nxt[m] != '0);
    assign cond[2*m+1] = (cnt_nxt[m] != FULL_CNT);
  end

  // ---------------- per-user status, interrupt and response ----------------
  for (genvar u = 0; u < NUM_USERS; u++) begin : g_user
    logic              acc;
    logic [SW-1:0]     ack;
    logic              en_we;
    logic [DATA_W-1:0] rmux;
    logic              rv_q;
    logic [DATA_W-1:0] rd_q;

    assign acc   = req_valid[u] && req_ready[u];
    assign ack   = (acc && req_write[u] && dec[u].sel == SEL_ISTAT) ?
                   wdat[u][SW-1:0] : '0;
    assign en_we = acc && req_write[u] && (dec[u].sel == SEL_IEN);

    mbx_irq_ctrl #(.SW(SW)) u_irq (
      .clk      (clk),
      .rst      (rst),
      .ack      (ack),
      .en_we    (en_we),
      .en_wdata (wdat[u][SW-1:0]),
      .cond     (cond),
      .stat     (stat_u[u]),
      .en       (en_u[u]),
      .irq      (irq[u])
    );

    always_comb begin
      rmux = '0;
      unique case (dec[u].sel)
        SEL_MSG: begin
          for (int m = 0; m < NUM_BOXES; m++)
            if (dec[u].box == 2'(m) && cnt_q[m] != '0) rmux = head[m];
        end
        SEL_CNT: begin
          for (int m = 0; m < NUM_BOXES; m++)
            if (dec[u].box == 2'(m)) rmux = DATA_W'(cnt_q[m]);
        end
        SEL_FULL: begin
          for (int m = 0; m < NUM_BOXES; m++)
            if (dec[u].box == 2'(m)) rmux = DATA_W'(cnt_q[m] == FULL_CNT);
        end
        SEL_ISTAT: rmux = DATA_W'(stat_u[u]);
        SEL_IEN:   rmux = DATA_W'(en_u[u]);
        default:   rmux = '0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        rv_q <= 1'b0;
        rd_q <= '0;
      end else begin
        rv_q <= acc && !req_write[u];
        if (acc && !req_write[u]) rd_q <= rmux;
      end
    end

    assign rsp_valid[u]                 = rv_q;
    assign rsp_data[u*DATA_W +: DATA_W] = rd_q;

    a_r2_rsp_follows_read: assert property (@(posedge clk) disable iff (rst)
      (req_valid[u] && req_ready[u] && !req_write[u]) |=> rsp_valid[u]);
    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (rst)
      (en_u[u] == '0) |-> !irq[u]);

    for (genvar m = 0; m < NUM_BOXES; m++) begin : g_lvl
      a_r7_newmsg_level: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && cnt_q[m] != '0) |-> stat_u[u][2*m]);
      a_r7_notfull_level: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && cnt_q[m] != FULL_CNT) |-> stat_u[u][2*m+1]);
    end
  end

endmodule

// File: tb/ipc_mailbox_tb_top.sv
module ipc_mailbox_tb_top;
  localparam int NU = 2;
  localparam int NB = 2;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NU-1:0] vld = '0;
  logic [NU-1:0] wr  = '0;
  logic [3:0]    ad [NU];
  logic [DW-1:0] wd [NU];
  logic [NU-1:0] req_ready, rsp_valid, irq;
  logic [NU*DW-1:0] rsp_data;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ipc_mailbox dut_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (vld),
    .req_ready (req_ready),
    .req_write (wr),
    .req_addr  ({ad[1], ad[0]}),
    .req_wdata ({wd[1], wd[0]}),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .irq       (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] mq [NB][$];
  logic [3:0]  st [NU];
  logic [3:0]  en [NU];
  logic        exp_rv [NU];
  logic [31:0] exp_rd [NU];

  always @(posedge clk) begin
    if (rst) begin
      for (int m = 0; m < NB; m++) mq[m].delete();
      for (int u = 0; u < NU; u++) begin
        st[u] = 0; en[u] = 0; exp_rv[u] = 0; exp_rd[u] = 0;
      end
    end else begin
      logic er [NU];
      logic popped [NB];
      int   pc [NB];
      logic [3:0] ack [NU];
      for (int u = 0; u < NU; u++) begin
        er[u] = 1;
        for (int v = 0; v < u; v++)
          if (vld[v] && vld[u] && ad[v] == ad[u] && ad[u] < NB && wr[v] == wr[u])
            er[u] = 0;
        chk("R6 req_ready", 32'(req_ready[u]), 32'(er[u]));
        ack[u] = 0;
      end
      for (int m = 0; m < NB; m++) begin pc[m] = mq[m].size(); popped[m] = 0; end
      for (int u = 0; u < NU; u++) begin
        exp_rv[u] = vld[u] && er[u] && !wr[u];
        if (exp_rv[u]) begin
          exp_rd[u] = 0;
          if (ad[u] < NB) begin
            if (mq[ad[u]].size() > 0) begin
              exp_rd[u] = mq[ad[u]].pop_front();
              popped[ad[u]] = 1;
            end
          end else if (ad[u] >= 4 && ad[u] < 4 + NB) exp_rd[u] = pc[ad[u]-4];
          else if (ad[u] >= 8 && ad[u] < 8 + NB) exp_rd[u] = 32'(pc[ad[u]-8] == 4);
          else if (ad[u] == 12) exp_rd[u] = 32'(st[u]);
          else if (ad[u] == 13) exp_rd[u] = 32'(en[u]);
        end
      end
      for (int u = 0; u < NU; u++) begin
        if (vld[u] && er[u] && wr[u]) begin
          if (ad[u] < NB) begin
            if (pc[ad[u]] < 4 || popped[ad[u]]) mq[ad[u]].push_back(wd[u]);
          end else if (ad[u] == 12) ack[u] = wd[u][3:0];
          else if (ad[u] == 13) en[u] = wd[u][3:0];
        end
      end
      for (int u = 0; u < NU; u++) begin
        logic [3:0] c;
        for (int m = 0; m < NB; m++) begin
          c[2*m]   = mq[m].size() > 0;
          c[2*m+1] = mq[m].size() < 4;
        end
        st[u] = (st[u] & ~ack[u]) | c;
      end
    end
  end

  always @(negedge clk) begin
    for (int u = 0; u < NU; u++) begin
      chk("R2 rsp_valid", 32'(rsp_valid[u]), 32'(exp_rv[u]));
      if (exp_rv[u]) chk("R2 rsp_data", rsp_data[u*DW +: DW], exp_rd[u]);
      chk("R9 irq", 32'(irq[u]), 32'(|(st[u] & en[u])));
    end
  end

  // ---------------- directed stimulus helpers ----------------
  task automatic op(input int u, input logic w, input logic [3:0] a, input logic [31:0] d);
    vld[u] = 1; wr[u] = w; ad[u] = a; wd[u] = d;
    @(negedge clk);
    vld[u] = 0;
  endtask

  task automatic rd_chk(input int u, input logic [3:0] a, input logic [31:0] exp, input string tag);
    op(u, 1'b0, a, 32'h0);
    chk(tag, rsp_data[u*DW +: DW], exp);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    for (int u = 0; u < NU; u++) begin ad[u] = 0; wd[u] = 0; end
    repeat (3) @(negedge clk);
    chk("R10 irq in reset", 32'(irq), 32'h0);
    chk("R10 rsp_valid in reset", 32'(rsp_valid), 32'h0);
    rst = 0;
    @(negedge clk);
    rd_chk(1, 4'd13, 32'h0, "R10 enable after reset");
    rd_chk(0, 4'd4,  32'h0, "R10 count after reset");

    // R1 / R7: three pushes, then level and status read-back
    op(0, 1, 4'd0, 32'hA0);
    op(0, 1, 4'd0, 32'hA1);
    op(0, 1, 4'd0, 32'hA2);
    rd_chk(1, 4'd4,  32'h3, "R1 count after three writes");
    rd_chk(1, 4'd12, 32'hB, "R7 status bits layout");

    // R2 / R4: drain in order, then empty read
    rd_chk(1, 4'd0, 32'hA0, "R2 oldest first");
    rd_chk(1, 4'd0, 32'hA1, "R2 second");
    rd_chk(1, 4'd0, 32'hA2, "R2 third");
    rd_chk(1, 4'd0, 32'h0,  "R4 empty read returns zero");
    rd_chk(1, 4'd4, 32'h0,  "R4 count stays zero");

    // R3: overfill mailbox 1
    for (int i = 0; i < 5; i++) op(1, 1, 4'd1, 32'hB0 + i);
    rd_chk(0, 4'd9, 32'h1, "R3 full flag");
    rd_chk(0, 4'd5, 32'h4, "R3 count saturates");
    op(0, 1, 4'd12, 32'h8);
    rd_chk(0, 4'd12, 32'h7, "R8 not-full ack while full clears");
    op(0, 1, 4'd12, 32'h4);
    rd_chk(0, 4'd12, 32'h7, "R8 new-message ack re-arms");
    op(0, 1, 4'd12, 32'h0);
    rd_chk(0, 4'd12, 32'h7, "R8 zero write no effect");
    for (int i = 0; i < 4; i++) rd_chk(0, 4'd1, 32'hB0 + i, "R3 kept words");
    rd_chk(0, 4'd1, 32'h0, "R3 fifth word dropped");
    rd_chk(0, 4'd12, 32'hF, "R7 not-full sets again");
    op(0, 1, 4'd12, 32'hF);
    rd_chk(0, 4'd12, 32'hA, "R8 ack clears empty events");

    // R9: enable mask and interrupt line
    op(0, 1, 4'd13, 32'h4);
    rd_chk(0, 4'd13, 32'h4, "R9 enable read-back");
    chk("R9 irq0 low before message", 32'(irq[0]), 32'h0);
    op(1, 1, 4'd1, 32'hC0);
    chk("R9 irq0 high on message", 32'(irq[0]), 32'h1);
    chk("R9 irq1 masked", 32'(irq[1]), 32'h0);
    op(0, 1, 4'd12, 32'h4);
    chk("R8 irq stays after ack with data", 32'(irq[0]), 32'h1);
    rd_chk(0, 4'd1, 32'hC0, "R2 pop interrupt message");
    op(0, 1, 4'd12, 32'h4);
    chk("R8 irq drops after ack on empty", 32'(irq[0]), 32'h0);

    // R5: write and read of one mailbox in one cycle
    op(0, 1, 4'd0, 32'hD0);
    op(0, 1, 4'd0, 32'hD1);
    vld = 2'b11; wr = 2'b01; ad[0] = 0; ad[1] = 0; wd[0] = 32'hD2;
    @(negedge clk); vld = 0;
    chk("R5 concurrent pop data", rsp_data[DW +: DW], 32'hD0);
    rd_chk(1, 4'd4, 32'h2, "R5 count unchanged");
    op(0, 1, 4'd0, 32'hD3);
    op(0, 1, 4'd0, 32'hD4);
    vld = 2'b11; wr = 2'b01; ad[0] = 0; ad[1] = 0; wd[0] = 32'hD5;
    @(negedge clk); vld = 0;
    chk("R5 concurrent pop on full", rsp_data[DW +: DW], 32'hD1);
    rd_chk(1, 4'd4, 32'h4, "R5 full count unchanged");
    for (int i = 2; i < 6; i++) rd_chk(1, 4'd0, 32'hD0 + i, "R5 order kept");

    // R6: write conflict on mailbox 1
    vld = 2'b11; wr = 2'b11; ad[0] = 1; ad[1] = 1; wd[0] = 32'hE0; wd[1] = 32'hE1;
    #1;
    chk("R6 conflict ready", 32'(req_ready), 32'h1);
    @(negedge clk); vld[0] = 0;
    #1;
    chk("R6 held request ready", 32'(req_ready[1]), 32'h1);
    @(negedge clk); vld[1] = 0;
    rd_chk(0, 4'd1, 32'hE0, "R6 winner first");
    rd_chk(0, 4'd1, 32'hE1, "R6 held write second");

    // R11: read-only and unmapped addresses
    op(0, 1, 4'd4, 32'h7);
    rd_chk(0, 4'd4,  32'h0, "R11 count write ignored");
    op(1, 1, 4'd15, 32'hFFFF);
    rd_chk(1, 4'd15, 32'h0, "R11 unmapped read zero");
    rd_chk(1, 4'd13, 32'h0, "R11 enable untouched");

    // mixed random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      for (int u = 0; u < NU; u++) begin
        vld[u] = 1'($urandom_range(0, 1));
        wr[u]  = 1'($urandom_range(0, 1));
        ad[u]  = 4'($urandom_range(0, 15));
        wd[u]  = $urandom;
      end
      @(negedge clk);
    end
    vld = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule